// File: doc/BRIEF.md
# Interleaving Read-Response Engine

This block sits on the slave side of an AXI4 read path. It accepts read-address requests with varied IDs and keeps up to `NCTX` bursts open at once in a small context table. On a single R channel it then returns data beats that may switch from one open burst to another on every beat. Each context holds the request's ID, its next address, the beats it still has to send, and its QoS value.

An arbiter picks one eligible context per cycle. The context with the highest QoS wins. Ties go to a round-robin pointer that moves past the winner after each issued beat, so bursts of equal QoS alternate beat by beat. The winner's address goes to a synchronous memory port with one cycle of read latency. The word that returns is presented as RDATA, together with the RID and RLAST tags that were registered when the beat was issued. A burst is never held back until the previous one has finished, and the master uses RID to sort the beats back into their bursts. The burst-type input is accepted, but every burst is stepped as INCR.

Top module: `rdil_engine`

## Requirements
- R1: Every R beat carries `s_rid` equal to the `s_arid` of the request it belongs to, and each accepted request with `s_arlen` = L yields exactly L+1 beats.
- R2: Beat k of a request (k counted from 0) carries the memory word read at address `s_araddr + k*(DATA_W/8)`. The memory port reads with `mem_rd_en` high and presents the word one cycle later on `mem_rdata`, which holds while `mem_rd_en` is low.
- R3: `s_rlast` is 1 on the final beat of each burst and 0 on every other beat.
- R4: Two open bursts with equal QoS alternate beat by beat. The earlier-accepted burst sends first. Example: ID 1 and ID 2, four beats each, accepted on consecutive cycles, give the RID order 1,2,1,2,1,2,1,2.
- R5: When more than one context may send, the beat comes from a context with the highest `s_arqos` among them.
- R6: While `s_rvalid` is 1 and `s_rready` is 0, the next cycle still has `s_rvalid` at 1, and `s_rid`, `s_rdata` and `s_rlast` are unchanged.
- R7: Beats that share an ID come out in address order, and bursts that share an ID finish in the order their requests were accepted.
- R8: The table holds `NCTX` (default 4) bursts. `s_arready` is 0 while all contexts are occupied, and a request offered then is accepted only after a context has been freed.
- R9: `s_rresp` is always 2'b00 (OKAY) while `s_rvalid` is 1.
- R10: A context is released on the clock edge at which its RLAST beat completes a handshake.
- R11: After reset, `s_rvalid` is 0 and `s_arready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_arvalid | input | 1 | Read-address valid |
| s_arready | output | 1 | Read-address ready (a free context exists) |
| s_arid | input | ID_W | Request ID |
| s_araddr | input | ADDR_W | Start address of the burst |
| s_arlen | input | LEN_W | Beats in the burst minus one |
| s_arburst | input | 2 | Burst type; every burst is stepped as INCR |
| s_arqos | input | QOS_W | Priority of the burst (larger value wins) |
| s_rvalid | output | 1 | Read-data valid |
| s_rready | input | 1 | Read-data ready from the master |
| s_rid | output | ID_W | ID tag of the current beat |
| s_rdata | output | DATA_W | Data of the current beat |
| s_rresp | output | 2 | Response code, always OKAY |
| s_rlast | output | 1 | Final beat of this beat's burst |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read word, one cycle after the strobe |

## Verification
The hardest case to reach is a QoS decision between bursts that are all open together. A burst that arrives alone begins issuing on the next cycle, so a later high-priority request would find the race already under way. The bench therefore holds `s_rready` low while several requests are accepted, which freezes the pipeline with one beat parked at the output, and then releases it. After that parked beat, the high-QoS burst must drain completely before the low-QoS burst resumes. The same stalling method fills the table, to show that `s_arready` drops and that a fifth request waits for a context to be released. A long phase with random back-pressure and reused IDs then checks ordering within each ID through a scoreboard keyed by RID.

// File: rtl/rdil_pkg.sv
package rdil_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY = 2'b00
  } rdil_resp_e;

  // INCR stepping: next beat address is the current one plus the beat width in bytes.
  function automatic logic [63:0] incr_step(input logic [63:0] cur, input int unsigned beat_bytes);
    return cur + 64'(beat_bytes);
  endfunction

  // A beat is the last of its burst when no further beats remain after it.
  function automatic logic is_final_beat(input logic [15:0] beats_left);
    return beats_left == 16'd0;
  endfunction

endpackage

// File: rtl/rdil_ctx_table.sv
module rdil_ctx_table #(
  parameter int NCTX       = 4,
  parameter int ID_W       = 4,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int QOS_W      = 4,
  parameter int BEAT_BYTES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             alloc_en,
  input  logic [ID_W-1:0]                  ar_id,
  input  logic [ADDR_W-1:0]                ar_addr,
  input  logic [LEN_W-1:0]                 ar_len,
  input  logic [QOS_W-1:0]                 ar_qos,
  input  logic                             issue_en,
  input  logic [((NCTX>1)?$clog2(NCTX):1)-1:0] issue_idx,
  input  logic                             free_en,
  input  logic [((NCTX>1)?$clog2(NCTX):1)-1:0] free_idx,
  output logic [NCTX-1:0]                  ctx_valid,
  output logic [NCTX-1:0]                  ctx_pending,
  output logic [NCTX-1:0][ID_W-1:0]        ctx_id,
  output logic [NCTX-1:0][ADDR_W-1:0]      ctx_addr,
  output logic [NCTX-1:0][LEN_W-1:0]       ctx_rem,
  output logic [NCTX-1:0][QOS_W-1:0]       ctx_qos,
  output logic [NCTX-1:0][NCTX-1:0]        ctx_older,
  output logic                             tbl_full
);
  import rdil_pkg::*;
  localparam int IDX_W = (NCTX > 1) ? $clog2(NCTX) : 1;

  logic [IDX_W-1:0] alloc_idx;

  assign tbl_full = &ctx_valid;

  always_comb begin
    alloc_idx = '0;
    for (int i = NCTX - 1; i >= 0; i--) begin
      if (!ctx_valid[i]) alloc_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_valid   <= '0;
      ctx_pending <= '0;
      ctx_id      <= '0;
      ctx_addr    <= '0;
      ctx_rem     <= '0;
      ctx_qos     <= '0;
      ctx_older   <= '0;
    end else begin
      for (int i = 0; i < NCTX; i++) begin
        if (free_en && free_idx == IDX_W'(i)) ctx_valid[i] <= 1'b0;
        if (issue_en && issue_idx == IDX_W'(i)) begin
          ctx_addr[i] <= ADDR_W'(incr_step(64'(ctx_addr[i]), BEAT_BYTES));
          ctx_rem[i]  <= ctx_rem[i] - 1'b1;
          if (is_final_beat(16'(ctx_rem[i]))) ctx_pending[i] <= 1'b0;
        end
        if (alloc_en && alloc_idx == IDX_W'(i)) begin
          ctx_valid[i]   <= 1'b1;
          ctx_pending[i] <= 1'b1;
          ctx_id[i]      <= ar_id;
          ctx_addr[i]    <= ar_addr;
          ctx_rem[i]     <= ar_len;
          ctx_qos[i]     <= ar_qos;
        end
        for (int j = 0; j < NCTX; j++) begin
          if (alloc_en && alloc_idx == IDX_W'(i))
            ctx_older[i][j] <= ctx_valid[j] && (j != i);
          else if (alloc_en && alloc_idx == IDX_W'(j))
            ctx_older[i][j] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rdil_arbiter.sv
module rdil_arbiter #(
  parameter int NCTX  = 4,
  parameter int ID_W  = 4,
  parameter int QOS_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              take,
  input  logic [NCTX-1:0]                   ctx_pending,
  input  logic [NCTX-1:0][ID_W-1:0]         ctx_id,
  input  logic [NCTX-1:0][QOS_W-1:0]        ctx_qos,
  input  logic [NCTX-1:0][NCTX-1:0]         ctx_older,
  output logic [NCTX-1:0]                   elig,
  output logic                              grant_any,
  output logic [((NCTX>1)?$clog2(NCTX):1)-1:0] grant_idx,
  output logic [NCTX-1:0]                   grant_vec
);
  localparam int IDX_W = (NCTX > 1) ? $clog2(NCTX) : 1;

  logic [IDX_W-1:0]  rr_ptr;
  logic [QOS_W-1:0]  top_qos;
  logic [NCTX-1:0]   cand;

  // A context may send unless an older context with the same ID still has beats to issue.
  always_comb begin
    for (int i = 0; i < NCTX; i++) begin
      elig[i] = ctx_pending[i];
      for (int j = 0; j < NCTX; j++) begin
        if (j != i && ctx_pending[j] && ctx_id[j] == ctx_id[i] && ctx_older[i][j])
          elig[i] = 1'b0;
      end
    end
  end

  always_comb begin
    top_qos = '0;
    for (int i = 0; i < NCTX; i++) begin
      if (elig[i] && ctx_qos[i] > top_qos) top_qos = ctx_qos[i];
    end
    for (int i = 0; i < NCTX; i++) cand[i] = elig[i] && (ctx_qos[i] == top_qos);
  end

  // Round-robin among the top-QoS candidates, starting just after the last winner.
  always_comb begin
    grant_any = 1'b0;
    grant_idx = '0;
    for (int k = 1; k <= NCTX; k++) begin
      int idx;
      idx = (int'(rr_ptr) + k) % NCTX;
      if (!grant_any && cand[idx]) begin
        grant_any = 1'b1;
        grant_idx = IDX_W'(idx);
      end
    end
    grant_vec = '0;
    if (grant_any) grant_vec[grant_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rr_ptr <= IDX_W'(NCTX - 1);
    else if (take) rr_ptr <= grant_idx;
  end
endmodule

// File: rtl/rdil_engine.sv
module rdil_engine #(
  parameter int NCTX   = 4,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int QOS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [LEN_W-1:0]  s_arlen,
  input  logic [1:0]        s_arburst,
  input  logic [QOS_W-1:0]  s_arqos,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ID_W-1:0]   s_rid,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata
);
  import rdil_pkg::*;
  localparam int IDX_W      = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam int BEAT_BYTES = DATA_W / 8;

  logic [NCTX-1:0]              ctx_valid, ctx_pending, elig, grant_vec;
  logic [NCTX-1:0][ID_W-1:0]    ctx_id;
  logic [NCTX-1:0][ADDR_W-1:0]  ctx_addr;
  logic [NCTX-1:0][LEN_W-1:0]   ctx_rem;
  logic [NCTX-1:0][QOS_W-1:0]   ctx_qos;
  logic [NCTX-1:0][NCTX-1:0]    ctx_older;
  logic                         tbl_full, grant_any;
  logic [IDX_W-1:0]             issue_idx, ridx_q;

  // Named internal events.
  logic ar_fire, pipe_adv, issue_en, issue_last, r_fire, r_done;
  logic rvalid_q, rlast_q;
  logic [ID_W-1:0] rid_q;
  logic unused_burst;

  assign unused_burst = ^s_arburst;
  assign s_arready    = !tbl_full;
  assign ar_fire      = s_arvalid && s_arready;
  assign pipe_adv     = !rvalid_q || s_rready;
  assign issue_en     = pipe_adv && grant_any;
  assign issue_last   = is_final_beat(16'(ctx_rem[issue_idx]));
  assign r_fire       = rvalid_q && s_rready;
  assign r_done       = r_fire && rlast_q;

  rdil_ctx_table #(
    .NCTX(NCTX), .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .QOS_W(QOS_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(ar_fire), .ar_id(s_arid), .ar_addr(s_araddr), .ar_len(s_arlen), .ar_qos(s_arqos),
    .issue_en(issue_en), .issue_idx(issue_idx),
    .free_en(r_done), .free_idx(ridx_q),
    .ctx_valid(ctx_valid), .ctx_pending(ctx_pending), .ctx_id(ctx_id), .ctx_addr(ctx_addr),
    .ctx_rem(ctx_rem), .ctx_qos(ctx_qos), .ctx_older(ctx_older), .tbl_full(tbl_full)
  );

  rdil_arbiter #(.NCTX(NCTX), .ID_W(ID_W), .QOS_W(QOS_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .take(issue_en),
    .ctx_pending(ctx_pending), .ctx_id(ctx_id), .ctx_qos(ctx_qos), .ctx_older(ctx_older),
    .elig(elig), .grant_any(grant_any), .grant_idx(issue_idx), .grant_vec(grant_vec)
  );

  assign mem_rd_en = issue_en;
  assign mem_addr  = ctx_addr[issue_idx];

  // Output stage: tags registered at issue, data arrives from memory one cycle later.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rid_q    <= '0;
      rlast_q  <= 1'b0;
      ridx_q   <= '0;
    end else if (pipe_adv) begin
      rvalid_q <= issue_en;
      rid_q    <= ctx_id[issue_idx];
      rlast_q  <= issue_last;
      ridx_q   <= issue_idx;
    end
  end

  assign s_rvalid = rvalid_q;
  assign s_rid    = rid_q;
  assign s_rlast  = rlast_q;
  assign s_rdata  = mem_rdata;
  assign s_rresp  = RESP_OKAY;
endmodule

// File: rtl/rdil_checker.sv
module rdil_checker #(
  parameter int NCTX   = 4,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int QOS_W  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          s_arready,
  input logic                          s_rvalid,
  input logic                          s_rready,
  input logic [ID_W-1:0]               s_rid,
  input logic [DATA_W-1:0]             s_rdata,
  input logic                          s_rlast,
  input logic [1:0]                    s_rresp,
  input logic [NCTX-1:0]               ctx_valid,
  input logic [NCTX-1:0]               ctx_pending,
  input logic [NCTX-1:0]               elig,
  input logic [NCTX-1:0][QOS_W-1:0]    ctx_qos,
  input logic [NCTX-1:0]               grant_vec,
  input logic                          issue_en,
  input logic [((NCTX>1)?$clog2(NCTX):1)-1:0] issue_idx,
  input logic [((NCTX>1)?$clog2(NCTX):1)-1:0] ridx_q
);
  function automatic logic outranked(input logic [NCTX-1:0] e,
                                     input logic [NCTX-1:0][QOS_W-1:0] q,
                                     input logic [QOS_W-1:0] w);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NCTX; i++) if (e[i] && q[i] > w) r = 1'b1;
    return r;
  endfunction

  AST_RESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> s_rresp == 2'b00); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rid) && $stable(s_rlast) && $stable(s_rdata))); // R6

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec)); // R4

  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> (ctx_pending[issue_idx] && elig[issue_idx])); // R7

  AST_QOS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> !outranked(elig, ctx_qos, ctx_qos[issue_idx])); // R5

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ctx_valid) == NCTX) |-> !s_arready); // R8

  AST_FREE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && s_rready && s_rlast) |=> !ctx_valid[$past(ridx_q)]); // R10
endmodule

bind rdil_engine rdil_checker #(.NCTX(NCTX), .ID_W(ID_W), .DATA_W(DATA_W), .QOS_W(QOS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_arready(s_arready), .s_rvalid(s_rvalid), .s_rready(s_rready),
  .s_rid(s_rid), .s_rdata(s_rdata), .s_rlast(s_rlast), .s_rresp(s_rresp),
  .ctx_valid(ctx_valid), .ctx_pending(ctx_pending), .elig(elig), .ctx_qos(ctx_qos),
  .grant_vec(grant_vec), .issue_en(issue_en), .issue_idx(issue_idx), .ridx_q(ridx_q)
);

// File: tb/tb_rdil_engine.sv
`timescale 1ns/1ps
module tb_rdil_engine;
  localparam int ID_W = 4, ADDR_W = 32, DATA_W = 32, LEN_W = 8, QOS_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_arvalid = 1'b0, s_arready;
  logic [ID_W-1:0] s_arid = '0;
  logic [ADDR_W-1:0] s_araddr = '0;
  logic [LEN_W-1:0] s_arlen = '0;
  logic [1:0] s_arburst = 2'b01;
  logic [QOS_W-1:0] s_arqos = '0;
  logic s_rvalid, s_rready = 1'b0, s_rlast;
  logic [ID_W-1:0] s_rid;
  logic [DATA_W-1:0] s_rdata;
  logic [1:0] s_rresp;
  logic mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata = '0;

  always #2 clk = ~clk;

  rdil_engine dut (.*);

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0F0F;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= word_at(mem_addr);

  int n_checks = 0, n_fail = 0;
  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed { logic [ID_W-1:0] id; logic [31:0] data; logic last; } exp_t;
  exp_t exp_q[$];
  logic [4:0] seq_q[$];

  int rr_mode = 0;
  always @(posedge clk) begin
    #1;
    case (rr_mode)
      0: s_rready = 1'b1;
      1: s_rready = 1'b0;
      default: s_rready = ($urandom % 3) != 0;
    endcase
  end

  task automatic send_ar(input int id, input logic [31:0] addr, input int len, input int qos);
    for (int k = 0; k <= len; k++)
      exp_q.push_back({ID_W'(id), word_at(addr + 32'(k * 4)), (k == len)});
    s_arvalid = 1'b1; s_arid = ID_W'(id); s_araddr = addr; s_arlen = LEN_W'(len); s_arqos = QOS_W'(qos);
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 1'b0;
  endtask

  logic prev_stall = 1'b0;
  logic [ID_W-1:0] p_id; logic [31:0] p_data; logic p_last;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(s_rvalid && s_rid == p_id && s_rdata == p_data && s_rlast == p_last, "R6 stall hold",
              {s_rid, s_rdata[27:0]}, {p_id, p_data[27:0]});
      if (s_rvalid && s_rready) begin
        int hit;
        hit = -1;
        for (int k = 0; k < exp_q.size(); k++) if (hit < 0 && exp_q[k].id == s_rid) hit = k;
        check(hit >= 0, "R1 unexpected rid", 32'(s_rid), 32'hFFFF_FFFF);
        check(s_rresp == 2'b00, "R9 rresp", 32'(s_rresp), 32'd0);
        if (hit >= 0) begin
          check(s_rdata == exp_q[hit].data, "R2/R7 rdata", s_rdata, exp_q[hit].data);
          check(s_rlast == exp_q[hit].last, "R3 rlast", 32'(s_rlast), 32'(exp_q[hit].last));
          exp_q.delete(hit);
        end
        seq_q.push_back({s_rid, s_rlast});
      end
      prev_stall = s_rvalid && !s_rready;
      p_id = s_rid; p_data = s_rdata; p_last = s_rlast;
    end
  end

  task automatic drain(input string req);
    for (int c = 0; c < 2000 && exp_q.size() != 0; c++) @(negedge clk);
    check(exp_q.size() == 0, req, 32'(exp_q.size()), 32'd0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!s_rvalid && s_arready, "R11 reset state", {s_rvalid, s_arready}, 32'b01);

    // R4 / R3: two equal-QoS four-beat bursts accepted back to back.
    seq_q.delete();
    send_ar(1, 32'h1000, 3, 0);
    send_ar(2, 32'h2000, 3, 0);
    drain("R1 two-burst drain");
    check(seq_q.size() == 8, "R4 beat count", 32'(seq_q.size()), 32'd8);
    if (seq_q.size() == 8)
      for (int k = 0; k < 8; k++) begin
        logic [4:0] e;
        e = {((k % 2) == 0) ? 4'd1 : 4'd2, k >= 6};
        check(seq_q[k] == e, "R4 interleave order", 32'(seq_q[k]), 32'(e));
      end

    // R5 / R6: stall output, accept low then high QoS, release.
    seq_q.delete();
    rr_mode = 1;
    send_ar(3, 32'h3000, 3, 1);
    send_ar(4, 32'h4000, 3, 8);
    repeat (6) @(negedge clk);
    check(s_rvalid && s_rid == 4'd3, "R6 parked beat", {s_rvalid, s_rid}, {1'b1, 4'd3});
    rr_mode = 0;
    drain("R5 qos drain");
    if (seq_q.size() == 8)
      for (int k = 0; k < 8; k++) begin
        logic [3:0] e;
        e = (k >= 1 && k <= 4) ? 4'd4 : 4'd3;
        check(seq_q[k][4:1] == e, "R5 qos order", 32'(seq_q[k][4:1]), 32'(e));
      end
    else check(1'b0, "R5 beat count", 32'(seq_q.size()), 32'd8);

    // R7: repeated ID mixed with another ID.
    send_ar(5, 32'h5000, 1, 2);
    send_ar(5, 32'h5800, 2, 2);
    send_ar(6, 32'h6000, 3, 2);
    drain("R7 same-id drain");

    // R8 / R10: fill the table while stalled, fifth request waits.
    rr_mode = 1;
    for (int k = 0; k < 4; k++) send_ar(7 + k, 32'h7000 + 32'(k * 32'h100), 0, 0);
    @(negedge clk);
    check(!s_arready, "R8 full table", 32'(s_arready), 32'd0);
    fork send_ar(11, 32'hB000, 1, 0); join_none
    repeat (4) @(negedge clk);
    check(s_arvalid && !s_arready, "R8 request held", {s_arvalid, s_arready}, 32'b10);
    rr_mode = 0;
    for (int c = 0; c < 50 && s_arvalid; c++) @(negedge clk);
    check(!s_arvalid, "R10 context reused", 32'(s_arvalid), 32'd0);
    drain("R10 drain");

    // Random back-pressure with reused IDs and single-beat bursts.
    rr_mode = 2;
    for (int n = 0; n < 40; n++)
      send_ar($urandom % 4, 32'h1_0000 + 32'(n * 32'h80), $urandom % 6, $urandom % 3);
    drain("R1 random drain");
    rr_mode = 0;
    repeat (3) @(negedge clk);
    check(!s_rvalid && s_arready, "R10 idle after drain", {s_rvalid, s_arready}, 32'b01);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule